// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets logic running on a single clock use an external static RAM that has no clock of its own. The RAM has a 17-bit address and an 8-bit bidirectional data bus. The host asks for one access at a time. It holds a request line high together with a direction bit, an address and, for a write, a data byte. The controller answers with a one-cycle acknowledge. On a read, the returned byte is already on the read-data port when the acknowledge is seen.

On the memory side, the controller drives the address, a pair of selects of opposite polarity (one active low, one active high), an active-low write strobe and an active-low output strobe. It also owns the output enable of the shared data bus. The RAM's nanosecond limits are given as parameters together with the clock period. Each limit is turned into a whole number of clock cycles, rounded up and never less than one. A small sequencer then steps every access through fixed phases of those lengths.

A write happens in the RAM only while both selects are active and the write strobe is low. It ends on whichever of them releases first. For this reason the controller raises the write strobe one full cycle before it drops the selects. The data has therefore been stable for the whole pulse before the edge that ends the write.

Top module: `sram_async_ctrl`

## Requirements
- R1: During reset and while idle, the low-active select is high, the high-active select is low, both strobes are high, the data bus is not driven and the acknowledge is low.
- R2: A read holds both selects active, the output strobe low and the write strobe high for exactly RD cycles, where RD = ceil(max(read cycle, address access, output access)/clock period), minimum 1. The byte on the bus in the last of those cycles appears on the read-data port in the following cycle, together with the acknowledge.
- R3: The two selects always switch together: the low-active select is low exactly when the high-active select is high.
- R4: A write starts with one cycle of active selects and a high write strobe. The write strobe is low only while both selects are active.
- R5: The controller drives the data bus only while the write strobe is low and during the recovery phase after it. The output strobe is high whenever it drives.
- R6: The write strobe stays low for exactly WE cycles, where WE = ceil(max(write pulse width, data setup, address-to-end)/clock period), minimum 1.
- R7: The driven byte equals the requested byte and does not change while it is driven. The memory address equals the request address for the whole access.
- R8: Each request gets one acknowledge pulse one cycle long. It is issued only after the write strobe is back high and with all memory strobes inactive, and it is followed by at least one idle cycle.
- R9: After a read, at least two cycles pass with the output strobe high before the write strobe of a following write falls.
- R10: After the write strobe rises, the selects stay active for REC = max(1, ceil(write cycle/clock period) − WE − 1) cycles.
- R11: A read returns the byte most recently written to the same address, including the lowest (0) and highest (0x1FFFF) addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Request, held high until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Access address |
| host_wdata | input | 8 | Byte to write |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Byte captured by the last read |
| sram_addr | output | 17 | Memory address |
| sram_ce1_n | output | 1 | Memory select, active low |
| sram_ce2 | output | 1 | Memory select, active high |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output strobe, active low |
| sram_dq | inout | 8 | Bidirectional memory data bus |

## Verification
The bench builds the controller with a 125 MHz clock against the 35 ns grade limits. None of these limits divides evenly by the 8 ns period, so every derived count is rounded up: five read cycles and a four-cycle write pulse. The write-cycle limit is already met by the setup and pulse phases, so the recovery phase falls back to its one-cycle floor, which exercises the minimum clamp. Its memory model records each write at the edge where the strobe overlap ends. It also measures how long the data was stable before that edge, which exposes any mutation that shortens or misplaces the strobe.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and cycle arithmetic for the asynchronous SRAM controller.
// Assumes all timing limits are non-negative integers in nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD   = 3'd1,
        ST_ACK  = 3'd2,
        ST_WSU  = 3'd3,
        ST_WPL  = 3'd4,
        ST_WRC  = 3'd5
    } seq_state_e;

    // Round a nanosecond limit up to whole clocks, never below one.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_step_timer.sv
// Down-counter for phase lengths. Loading N-1 marks the current phase as
// lasting N cycles; expired is high in the last cycle of the phase.
module sram_step_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on phase entry, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
// Access sequencer: walks each request through its strobe phases and
// registers every memory strobe so the pins change only on clock edges.
// Assumes the host keeps host_req high until it sees the acknowledge.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC   = 5,
    parameter int WE_CYC   = 4,
    parameter int WREC_CYC = 1,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_write,
    input  logic             expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             accept,
    output logic             capture,
    output logic             drive_en,
    output logic             ce1_n,
    output logic             ce2,
    output logic             we_n,
    output logic             oe_n,
    output logic             ack
);
    localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WE_LD   = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] WREC_LD = CNT_W'(WREC_CYC - 1);

    seq_state_e state_q, nxt;
    logic       sel_nxt;
    logic [CNT_W:0] we_run_q;

    // Next-phase choice and timer reload for the phase being entered.
    always_comb begin
        nxt      = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: if (req) begin
                if (req_write) nxt = ST_WSU;
                else begin
                    nxt = ST_RD; tmr_load = 1'b1; tmr_val = RD_LD;
                end
            end
            ST_RD:  if (expired) nxt = ST_ACK;
            ST_ACK: nxt = ST_IDLE;
            ST_WSU: begin nxt = ST_WPL; tmr_load = 1'b1; tmr_val = WE_LD; end
            ST_WPL: if (expired) begin
                nxt = ST_WRC; tmr_load = 1'b1; tmr_val = WREC_LD;
            end
            ST_WRC: if (expired) nxt = ST_ACK;
            default: nxt = ST_IDLE;
        endcase
    end

    assign accept  = (state_q == ST_IDLE) && req;
    assign capture = (state_q == ST_RD) && expired;
    assign sel_nxt = (nxt == ST_RD) || (nxt == ST_WSU) ||
                     (nxt == ST_WPL) || (nxt == ST_WRC);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // Registered strobes, decoded from the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce1_n    <= 1'b1;
            ce2      <= 1'b0;
            we_n     <= 1'b1;
            oe_n     <= 1'b1;
            drive_en <= 1'b0;
            ack      <= 1'b0;
        end else begin
            ce1_n    <= !sel_nxt;
            ce2      <= sel_nxt;
            we_n     <= (nxt != ST_WPL);
            oe_n     <= (nxt != ST_RD);
            drive_en <= (nxt == ST_WPL) || (nxt == ST_WRC);
            ack      <= (nxt == ST_ACK);
        end
    end

    // Length of the current write-strobe pulse, used by the pulse check.
    always_ff @(posedge clk) begin
        if (!rst_n || we_n)             we_run_q <= '0;
        else if (we_run_q != '1)        we_run_q <= we_run_q + 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (ce1_n && !ce2 && we_n && oe_n && !drive_en)); // R1
    AST_DRIVE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> oe_n); // R5
    AST_WE_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_run_q >= (CNT_W+1)'(WE_CYC))); // R6
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R8
endmodule

// File: rtl/sram_data_path.sv
// Holds the request address and write byte for the whole access, drives
// the shared bus when enabled and samples read data on capture.
module sram_data_path #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic              drive_en,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic [DATA_W-1:0] rd_data
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_q;

    // Latch the request when the sequencer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the bus at the end of the last read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_q <= '0;
        else if (capture) rd_q <= mem_dq;
    end

    assign mem_dq   = drive_en ? wdata_q : {DATA_W{1'bz}};
    assign mem_addr = addr_q;
    assign rd_data  = rd_q;

    AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en && $past(drive_en)) |-> ($stable(wdata_q) && $stable(addr_q))); // R7
    AST_NO_CAPTURE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !drive_en); // R5
endmodule

// File: rtl/sram_async_ctrl.sv
// Top of the asynchronous SRAM controller. Converts nanosecond limits
// into cycle counts and wires the sequencer, phase timer and data path.
// Assumes one outstanding request and a memory with separate selects.
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 8,
    parameter int T_RC_NS   = 35,
    parameter int T_AA_NS   = 35,
    parameter int T_DOE_NS  = 10,
    parameter int T_WC_NS   = 35,
    parameter int T_PWE_NS  = 25,
    parameter int T_SD_NS   = 20,
    parameter int T_AW_NS   = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    inout  wire  [DATA_W-1:0] sram_dq
);
    localparam int RD_CYC   = imax(ns_to_cycles(T_RC_NS, CLK_NS),
                              imax(ns_to_cycles(T_AA_NS, CLK_NS),
                                   ns_to_cycles(T_DOE_NS, CLK_NS)));
    localparam int WE_CYC   = imax(ns_to_cycles(T_PWE_NS, CLK_NS),
                              imax(ns_to_cycles(T_SD_NS, CLK_NS),
                                   ns_to_cycles(T_AW_NS, CLK_NS)));
    localparam int WREC_CYC = imax(1, ns_to_cycles(T_WC_NS, CLK_NS) - WE_CYC - 1);
    localparam int CNT_W    = $clog2(imax(RD_CYC, imax(WE_CYC, WREC_CYC)) + 1);

    logic             tmr_load, expired, accept, capture, drive_en;
    logic [CNT_W-1:0] tmr_val;
    logic             oe_hi_d1, oe_hi_d2;

    sram_step_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(expired)
    );

    sram_seq #(
        .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .WREC_CYC(WREC_CYC), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req(host_req), .req_write(host_we),
        .expired(expired), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .accept(accept), .capture(capture), .drive_en(drive_en),
        .ce1_n(sram_ce1_n), .ce2(sram_ce2), .we_n(sram_we_n),
        .oe_n(sram_oe_n), .ack(host_ack)
    );

    sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(host_addr),
        .req_wdata(host_wdata), .capture(capture), .drive_en(drive_en),
        .mem_addr(sram_addr), .mem_dq(sram_dq), .rd_data(host_rdata)
    );

    // History of the output strobe for the bus turnaround check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_hi_d1 <= 1'b1;
            oe_hi_d2 <= 1'b1;
        end else begin
            oe_hi_d1 <= sram_oe_n;
            oe_hi_d2 <= oe_hi_d1;
        end
    end

    AST_WE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce1_n && sram_ce2)); // R4
    AST_ACK_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (sram_we_n && sram_ce1_n && !sram_ce2 && sram_oe_n)); // R8
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> (sram_oe_n && oe_hi_d1 && oe_hi_d2)); // R9
endmodule

// File: tb/tb_sram_async_ctrl.sv
// Self-checking bench: behavioural memory model plus per-cycle strobe checks.
module tb_sram_async_ctrl;
    localparam int CLK_NS = 8;

    function automatic int cyc_up(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        return (c < 1) ? 1 : c;
    endfunction

    // Expected phase lengths from the requirements for the 35 ns grade.
    localparam int RD_EXP   = 5;   // max(35,35,10)/8 rounded up
    localparam int WE_EXP   = 4;   // max(25,20,25)/8 rounded up
    localparam int WREC_EXP = 1;   // max(1, 5-4-1)
    localparam int SD_EXP   = 3;   // 20/8 rounded up

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_req, host_we, host_ack;
    logic [16:0] host_addr, sram_addr;
    logic [7:0]  host_wdata, host_rdata;
    logic        sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n;
    wire  [7:0]  sram_dq;

    logic [7:0]  model_out;
    logic        model_drv;
    logic [7:0]  store [int];
    logic [7:0]  expect_mem [int];

    int total = 0;
    int bad   = 0;
    int ncyc  = 0;
    int last_oe_low = -100;
    bit prev_w = 1'b0, prev_we_n = 1'b1;
    int plen = 0, stab = 0;
    logic [7:0]  last_d;
    logic [16:0] last_a;

    always #4 clk = ~clk;

    sram_async_ctrl dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .sram_addr(sram_addr),
        .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_dq(sram_dq)
    );

    assign model_drv = !sram_ce1_n && sram_ce2 && sram_we_n && !sram_oe_n;
    assign sram_dq   = model_drv ? model_out : 8'hzz;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_at(input logic [16:0] a);
        return expect_mem.exists(int'(a)) ? expect_mem[int'(a)] : 8'h00;
    endfunction

    // Memory model and per-cycle monitors, evaluated away from the clock edge.
    always @(negedge clk) begin
        bit w_act;
        ncyc++;
        if (rst_n) begin
            chk(sram_ce1_n == !sram_ce2, "R3", "select pair", {sram_ce1_n, sram_ce2}, 0);
            if (!sram_we_n)
                chk(!sram_ce1_n && sram_ce2, "R4", "we outside select", {sram_ce1_n, sram_ce2}, 2'b01);
            if (model_drv)
                chk(sram_dq == model_out, "R5", "bus contention", sram_dq, model_out);
            if (prev_we_n && !sram_we_n)
                chk(ncyc - last_oe_low >= 3, "R9", "read to write gap", ncyc - last_oe_low, 3);
            if (!sram_oe_n) last_oe_low = ncyc;
            prev_we_n = sram_we_n;
            w_act = !sram_ce1_n && sram_ce2 && !sram_we_n;
            if (w_act) begin
                if (prev_w && sram_dq == last_d) stab++;
                else stab = 1;
                plen   = prev_w ? plen + 1 : 1;
                last_d = sram_dq;
                last_a = sram_addr;
            end else if (prev_w) begin
                store[int'(last_a)] = last_d;
                chk(plen >= WE_EXP, "R6", "short write pulse", plen, WE_EXP);
                chk(stab >= SD_EXP, "R7", "data setup before write end", stab, SD_EXP);
            end
            prev_w = w_act;
        end
        model_out <= store.exists(int'(sram_addr)) ? store[int'(sram_addr)] : 8'h00;
    end

    // Watchdog: a hung run ends as a failure.
    always @(posedge clk) begin
        if (ncyc > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<20000", ncyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle_after_ack(input string rq);
        host_req = 1'b0;
        @(negedge clk);
        chk(!host_ack, rq, "ack longer than one cycle", host_ack, 0);
        chk(sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n, "R1", "idle strobes",
            {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n}, 4'b1011);
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d);
        host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        chk(!sram_ce1_n && sram_ce2 && sram_we_n && sram_oe_n, "R4", "setup phase",
            {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n}, 4'b0111);
        chk(sram_addr == a, "R7", "write address", sram_addr, a);
        for (int i = 0; i < WE_EXP; i++) begin
            @(negedge clk);
            chk(!sram_we_n, "R6", "write strobe low", sram_we_n, 0);
            chk(sram_oe_n, "R5", "oe high while driving", sram_oe_n, 1);
            chk(sram_dq == d, "R7", "write data", sram_dq, d);
            chk(!host_ack, "R8", "early ack", host_ack, 0);
        end
        for (int i = 0; i < WREC_EXP; i++) begin
            @(negedge clk);
            chk(sram_we_n && !sram_ce1_n && sram_ce2, "R10", "recovery phase",
                {sram_we_n, sram_ce1_n, sram_ce2}, 3'b101);
            chk(sram_dq == d, "R7", "hold data", sram_dq, d);
        end
        @(negedge clk);
        chk(host_ack, "R8", "write ack", host_ack, 1);
        chk(sram_ce1_n && !sram_ce2 && sram_we_n, "R8", "strobes off at ack",
            {sram_ce1_n, sram_ce2, sram_we_n}, 3'b101);
        expect_mem[int'(a)] = d;
        idle_after_ack("R8");
    endtask

    task automatic do_read(input logic [16:0] a);
        host_req = 1'b1; host_we = 1'b0; host_addr = a;
        for (int i = 0; i < RD_EXP; i++) begin
            @(negedge clk);
            chk(!sram_ce1_n && sram_ce2 && !sram_oe_n && sram_we_n, "R2", "read phase",
                {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n}, 4'b0101);
            chk(sram_addr == a, "R7", "read address", sram_addr, a);
            chk(!host_ack, "R2", "early ack", host_ack, 0);
        end
        @(negedge clk);
        chk(host_ack, "R2", "read ack", host_ack, 1);
        chk(sram_oe_n && sram_ce1_n, "R2", "read phase length", {sram_oe_n, sram_ce1_n}, 2'b11);
        chk(host_rdata == exp_at(a), "R11", "read data", host_rdata, exp_at(a));
        idle_after_ack("R8");
    endtask

    initial begin
        rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0;
        host_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        chk(sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !host_ack, "R1",
            "reset levels", {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, host_ack}, 5'b10110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sram_ce1_n && !sram_ce2 && sram_we_n && sram_oe_n && !host_ack, "R1",
            "idle after reset", {sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, host_ack}, 5'b10110);

        do_write(17'h00010, 8'h5A);
        do_read(17'h00010);
        do_write(17'h00000, 8'hFF);
        do_write(17'h1FFFF, 8'h00);
        do_write(17'h1FFFF, 8'hC3);
        do_read(17'h00000);
        do_read(17'h1FFFF);
        do_read(17'h0ABCD);
        for (int i = 0; i < 8; i++)
            do_write(17'(i * 4099 + 7), 8'(i * 37 + 1));
        for (int i = 7; i >= 0; i--) begin
            do_read(17'(i * 4099 + 7));
            do_write(17'(i * 4099 + 7), 8'(~(i * 37 + 1)));
        end
        for (int i = 0; i < 8; i++)
            do_read(17'(i * 4099 + 7));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule